// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a watchdog that software programs over a simple register port and keeps alive with periodic writes. A down-counter of configurable width, 32 bits by default, decrements once for each pulse on a core tick strobe. When it runs out, it reloads from a programmed start value and raises an interrupt. If software has not cleared that interrupt by the next run-out, and resets are permitted, the block raises a system reset request. That request holds until the block itself is reset. The worst-case time from the last keep-alive to the reset is therefore two full load periods.

Every register is write-protected. Writes take effect only after the 32-bit key 0x1ACCE551 has been written to the lock register. Any other value written there closes the register file again. Reads are never blocked. The bus side uses a combinational read mux and a single-cycle write strobe, and both run on the same clock as the counter.

Top module: `twostage_wdog`

## Requirements
- R1: After reset the block is locked, CONTROL reads 0, STATUS reads 0, LOAD and VALUE read 0xFFFFFFFF, and both `irq` and `rst_req` are low.
- R2: Writing 0x1ACCE551 to the lock register (offset 0xC00) unlocks the block. Any other value locks it. Reading the lock register returns 1 in bit 0 while locked and 0 while unlocked.
- R3: While locked, writes to LOAD (0x000), CONTROL (0x008) and CLEAR (0x00C) change nothing.
- R4: CONTROL (0x008) bit 0 runs the counter and enables the expiry interrupt. Bit 1 permits the reset request. Bits 31:2 read as zero whatever is written.
- R5: While running, VALUE (0x004) drops by one on each clock that has `tick` high. It does not change on clocks without `tick`.
- R6: A tick that finds VALUE at 1 or below is an expiry. On that same edge VALUE reloads from LOAD and `irq` is set, and STATUS (0x014) then reads nonzero.
- R7: Writing a value with bit 0 set to CLEAR (0x00C) drops `irq` and reloads VALUE from LOAD. A write with bit 0 clear has no effect.
- R8: An expiry while `irq` is still set and CONTROL bit 1 is set raises `rst_req`. `rst_req` stays high until `rst_n` is asserted, even across a clear.
- R9: An expiry while `irq` is still set and CONTROL bit 1 is clear leaves `rst_req` low.
- R10: Clearing CONTROL bit 0 freezes VALUE. Setting it again resumes counting from the frozen value.
- R11: Writing LOAD leaves VALUE untouched until the next reload, which comes from either a clear or an expiry.
- R12: When a clear and an expiring tick fall on the same clock, the clear wins: VALUE reloads and `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and counter |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Core tick strobe, one count per high cycle |
| addr | input | 12 | Register byte offset |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Expiry interrupt, level |
| rst_req | output | 1 | System reset request, sticky level |

## Verification
The keep-alive clear and a counter expiry can land on the same clock edge. The first would drop the interrupt while the second would set it, and with a pending interrupt it could also escalate to reset. The bench runs the counter down to 1 and then applies a clear write and a tick together in one cycle. It expects VALUE to come back at LOAD with `irq` and `rst_req` both low, and one further tick then only decrements. The escalation path is also checked alone, with and without reset permission, so that the tie-break can be told apart from a blocked escalation.

// File: rtl/twostage_wdog_pkg.sv
// Shared constants for the two-stage watchdog: register offsets, unlock key
// and the control field layout. Assumes a 12-bit byte-offset bus address.
package twostage_wdog_pkg;
    localparam int          ADDR_W      = 12;
    localparam logic [11:0] OFF_LOAD    = 12'h000;
    localparam logic [11:0] OFF_COUNT   = 12'h004;
    localparam logic [11:0] OFF_CTRL    = 12'h008;
    localparam logic [11:0] OFF_CLEAR   = 12'h00C;
    localparam logic [11:0] OFF_STAT    = 12'h014;
    localparam logic [11:0] OFF_LOCK    = 12'hC00;
    localparam logic [31:0] UNLOCK_KEY  = 32'h1ACC_E551;

    typedef struct packed {
        logic rst_en;   // bit 1: reset request permitted
        logic run;      // bit 0: counter and interrupt enabled
    } ctrl_t;
endpackage

// File: rtl/wdog_regfile.sv
// Register file of the watchdog: lock, control, load value, keep-alive strobe
// and the read mux. Assumes one write per cycle and reads with no side effect.
module wdog_regfile
    import twostage_wdog_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              wr_en,
    input  logic [DW-1:0]     cnt,
    input  logic              irq_pend,
    output logic [31:0]       rdata,
    output ctrl_t             ctrl_o,
    output logic [DW-1:0]     load_o,
    output logic              clear_o
);
    logic locked_q;
    logic wr_ok;

    // Writes other than to the lock pass only while unlocked.
    always_comb wr_ok = wr_en && !locked_q;

    // Keep-alive strobe: an unlocked write of bit 0 to CLEAR.
    always_comb clear_o = wr_ok && (addr == OFF_CLEAR) && wdata[0];

    // Lock state: the key opens it, any other value closes it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked_q <= 1'b1;
        else if (wr_en && addr == OFF_LOCK)
            locked_q <= (wdata != UNLOCK_KEY);
    end

    // Control and load registers, writable only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o <= '0;
            load_o <= '1;
        end else if (wr_ok) begin
            if (addr == OFF_CTRL) ctrl_o <= ctrl_t'(wdata[1:0]);
            if (addr == OFF_LOAD) load_o <= wdata[DW-1:0];
        end
    end

    // Read mux; unmapped offsets read zero.
    always_comb begin
        rdata = '0;
        case (addr)
            OFF_LOAD:  rdata = 32'(load_o);
            OFF_COUNT: rdata = 32'(cnt);
            OFF_CTRL:  rdata = {30'b0, ctrl_o};
            OFF_STAT:  rdata = {31'b0, irq_pend};
            OFF_LOCK:  rdata = {31'b0, locked_q};
            default:   rdata = '0;
        endcase
    end

    // R3: a locked write to any other register leaves the configuration intact.
    p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && wr_en && addr != OFF_LOCK) |=> ($stable(load_o) && $stable(ctrl_o)));
    // R2: the lock opens only on the key.
    p_key_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_LOCK && wdata != UNLOCK_KEY) |=> locked_q);
endmodule

// File: rtl/wdog_counter.sv
// Down-counter of the watchdog. It steps on core ticks while running,
// reloads on a keep-alive or on expiry, and flags expiry for one cycle.
// Assumes a keep-alive takes priority over a tick in the same cycle.
module wdog_counter #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic          reload_req,
    input  logic [DW-1:0] load_val,
    output logic [DW-1:0] count_o,
    output logic          expire_o
);
    localparam logic [DW-1:0] ONE = DW'(1);

    // Expiry: a counting tick that finds the count at one or below.
    always_comb expire_o = run && tick && !reload_req && (count_o <= ONE);

    // Counter state: reload, step, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_o <= '1;
        else if (reload_req || expire_o)
            count_o <= load_val;
        else if (run && tick)
            count_o <= count_o - ONE;
    end

    // R6: an expiry leaves the load value in the counter.
    p_reload_on_expire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> (count_o == $past(load_val)));
    // R5: an ordinary tick moves the count down by exactly one.
    p_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !reload_req && count_o > ONE) |=> (count_o == $past(count_o) - ONE));
    // R10: when halted and not reloaded the count holds.
    p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reload_req) |=> $stable(count_o));
endmodule

// File: rtl/wdog_escalate.sv
// Escalation stage: the first expiry raises the interrupt, and an expiry
// with the interrupt still pending raises a sticky reset request if permitted.
// Assumes expiry and clear never arrive in the same cycle.
module wdog_escalate (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clear,
    input  logic rst_en,
    output logic irq_o,
    output logic rst_req_o
);
    // Interrupt pending flag: set on expiry, dropped by a keep-alive.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_o <= 1'b0;
        else if (clear)
            irq_o <= 1'b0;
        else if (expire)
            irq_o <= 1'b1;
    end

    // Reset request: latched on a second expiry, freed only by block reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_req_o <= 1'b0;
        else if (expire && irq_o && rst_en)
            rst_req_o <= 1'b1;
    end

    // R8: once raised, the reset request never falls without a reset.
    p_rst_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> rst_req_o);
    // R8: the request rises only after an expiry met a pending interrupt.
    p_rst_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> ($past(irq_o) && $past(rst_en) && $past(expire)));
    // R9: without permission an expiry cannot start a reset.
    p_no_rst_unpermitted_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_en && !rst_req_o) |=> !rst_req_o);
    // R7: a keep-alive always drops the interrupt.
    p_clear_drops_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !irq_o);
endmodule

// File: rtl/twostage_wdog.sv
// Top of the two-stage lockable watchdog: register file, counter and
// escalation stage. Assumes bus and tick share one clock domain.
module twostage_wdog
    import twostage_wdog_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic [11:0] addr,
    input  logic [31:0] wdata,
    input  logic        wr_en,
    output logic [31:0] rdata,
    output logic        irq,
    output logic        rst_req
);
    ctrl_t         ctrl;
    logic [DW-1:0] load_val;
    logic [DW-1:0] count;
    logic          clear;
    logic          expire;

    wdog_regfile #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .cnt(count), .irq_pend(irq), .rdata(rdata), .ctrl_o(ctrl),
        .load_o(load_val), .clear_o(clear)
    );

    wdog_counter #(.DW(DW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .tick(tick),
        .reload_req(clear), .load_val(load_val), .count_o(count),
        .expire_o(expire)
    );

    wdog_escalate u_esc (
        .clk(clk), .rst_n(rst_n), .expire(expire), .clear(clear),
        .rst_en(ctrl.rst_en), .irq_o(irq), .rst_req_o(rst_req)
    );

    // R12: a keep-alive and an expiry are never reported together.
    p_clear_beats_expire_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(clear && expire));
endmodule

// File: tb/twostage_wdog_bench.sv
module twostage_wdog_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic [31:0] rdata;
    logic        irq;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    twostage_wdog u_twostage_wdog (
        .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rdata(rdata), .irq(irq), .rst_req(rst_req)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] a;
        logic [31:0] d;
        logic [31:0] e;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 12'h000, 32'd5,          32'd0,          8'd3},  // R3 locked LOAD write
        '{1'b0, 12'h000, 32'd0,          32'hFFFF_FFFF,  8'd3},
        '{1'b1, 12'h008, 32'd3,          32'd0,          8'd3},  // R3 locked CONTROL write
        '{1'b0, 12'h008, 32'd0,          32'd0,          8'd3},
        '{1'b1, 12'hC00, 32'h1234_5678,  32'd0,          8'd2},  // R2 wrong key
        '{1'b0, 12'hC00, 32'd0,          32'd1,          8'd2},
        '{1'b1, 12'hC00, 32'h1ACC_E551,  32'd0,          8'd2},  // R2 right key
        '{1'b0, 12'hC00, 32'd0,          32'd0,          8'd2},
        '{1'b1, 12'hC00, 32'h1ACC_E550,  32'd0,          8'd2},  // R2 relock
        '{1'b0, 12'hC00, 32'd0,          32'd1,          8'd2},
        '{1'b1, 12'hC00, 32'h1ACC_E551,  32'd0,          8'd2},
        '{1'b1, 12'h008, 32'hFFFF_FFFE,  32'd0,          8'd4},  // R4 reserved bits
        '{1'b0, 12'h008, 32'd0,          32'd2,          8'd4},
        '{1'b1, 12'h008, 32'd0,          32'd0,          8'd4},
        '{1'b0, 12'h008, 32'd0,          32'd0,          8'd4},
        '{1'b1, 12'h000, 32'd10,         32'd0,          8'd11}, // R11 LOAD write
        '{1'b0, 12'h000, 32'd0,          32'd10,         8'd11},
        '{1'b0, 12'h004, 32'd0,          32'hFFFF_FFFF,  8'd11},
        '{1'b1, 12'h00C, 32'hFFFF_FFFE,  32'd0,          8'd7},  // R7 bit 0 clear
        '{1'b0, 12'h004, 32'd0,          32'hFFFF_FFFF,  8'd7},
        '{1'b1, 12'h00C, 32'd1,          32'd0,          8'd7},  // R7 keep-alive
        '{1'b0, 12'h004, 32'd0,          32'd10,         8'd7}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        @(negedge clk);
        do_reset();

        // R1 reset state
        rd(12'hC00, v); check("R1 lock", v, 32'd1);
        rd(12'h004, v); check("R1 value", v, 32'hFFFF_FFFF);
        rd(12'h000, v); check("R1 load", v, 32'hFFFF_FFFF);
        rd(12'h008, v); check("R1 control", v, 32'd0);
        rd(12'h014, v); check("R1 status", v, 32'd0);
        check("R1 irq", {31'b0, irq}, 32'd0);
        check("R1 rst_req", {31'b0, rst_req}, 32'd0);

        // register table, tick held low
        for (int i = 0; i < NV; i++) begin
            if (TBL[i].wr) wr(TBL[i].a, TBL[i].d);
            else begin
                rd(TBL[i].a, v);
                check($sformatf("R%0d table[%0d]", TBL[i].req, i), v, TBL[i].e);
            end
        end

        // R10/R5: halted counter ignores ticks
        ticks(3);
        rd(12'h004, v); check("R10 halted", v, 32'd10);
        wr(12'h008, 32'd1);
        ticks(3);
        rd(12'h004, v); check("R5 three ticks", v, 32'd7);
        repeat (2) @(negedge clk);
        rd(12'h004, v); check("R5 no tick", v, 32'd7);
        wr(12'h008, 32'd0);
        ticks(2);
        rd(12'h004, v); check("R10 frozen", v, 32'd7);
        wr(12'h008, 32'd1);
        ticks(1);
        rd(12'h004, v); check("R10 resume", v, 32'd6);

        // R11: new LOAD waits for reload
        wr(12'h000, 32'd4);
        rd(12'h004, v); check("R11 count kept", v, 32'd6);
        ticks(5);
        rd(12'h004, v); check("R11 at one", v, 32'd1);
        check("R6 no irq yet", {31'b0, irq}, 32'd0);
        ticks(1);
        rd(12'h004, v); check("R6 reload", v, 32'd4);
        check("R6 irq", {31'b0, irq}, 32'd1);
        rd(12'h014, v); check("R6 status", {31'b0, v != 0}, 32'd1);

        // R9: second expiry without permission
        ticks(4);
        check("R9 irq held", {31'b0, irq}, 32'd1);
        check("R9 no reset", {31'b0, rst_req}, 32'd0);
        wr(12'h00C, 32'd1);
        check("R7 irq dropped", {31'b0, irq}, 32'd0);

        // R12: clear and expiring tick together
        ticks(3);
        rd(12'h004, v); check("R12 setup", v, 32'd1);
        addr = 12'h00C; wdata = 32'd1; wr_en = 1'b1; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        rd(12'h004, v); check("R12 reload", v, 32'd4);
        check("R12 irq low", {31'b0, irq}, 32'd0);
        ticks(1);
        rd(12'h004, v); check("R12 step after", v, 32'd3);
        check("R12 still low", {31'b0, irq}, 32'd0);

        // R8: escalation with permission
        wr(12'h008, 32'd3);
        ticks(3);
        check("R8 first expiry", {31'b0, irq}, 32'd1);
        check("R8 not yet", {31'b0, rst_req}, 32'd0);
        ticks(4);
        check("R8 reset raised", {31'b0, rst_req}, 32'd1);
        wr(12'h00C, 32'd1);
        check("R8 sticky", {31'b0, rst_req}, 32'd1);
        check("R7 irq cleared", {31'b0, irq}, 32'd0);

        // R1: block reset frees the request and relocks
        do_reset();
        check("R1 rst_req freed", {31'b0, rst_req}, 32'd0);
        rd(12'hC00, v); check("R1 relocked", v, 32'd1);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule